// File: doc/BRIEF.md
# Coprocessor Handshake Responder

This block is the coprocessor-side half of a two-wire handshake with a host processor. It keeps its own three-stage model of the host pipeline (fetch, decode, execute). The model is filled from the instruction words the host fetches over the shared data bus, and it advances one stage per clock unless the host stalls. A word that moves from decode into execute is decoded once. If it is a coprocessor-class instruction carrying this unit's number, the unit answers on two response lines, `resp_absent` and `resp_busy`, while the host still decides whether to issue it.

The unit commits only when the host pulls its active-low issue strobe `host_cop_n` low. The execution model has an internal not-ready time: a per-instruction latency field, clamped to a parameter. During that time the unit holds the busy line high, and the host stays stalled with the strobe low. The busy line drops in the first cycle the unit can start. Execution is one write into a local register bank. If the host lifts the strobe while the unit is still busy, the instruction is dropped with no side effect and tracking carries on.

Top module: `cophs_unit`

## Requirements
- R1: A word is relevant only if bits [27:24] equal 1110 or bits [27:25] equal 110, and bits [11:8] equal the parameter CP_ID. For any other word in execute, both response lines are high.
- R2: The pair (absent, busy) takes only the codes 00 (can start now), 01 (busy-wait) and 11 (absent). The code 10 is never driven.
- R3: The response for a relevant word is valid in its first cycle in execute, before the host strobe has gone low.
- R4: No register write happens in a cycle where `host_cop_n` is high.
- R5: For a relevant word, busy stays high for N strobe-low cycles, and absent stays low throughout. N is bits [23:20] clamped to MAX_WAIT. In the next strobe-low cycle, busy is low and the write happens.
- R6: If the strobe returns high after being low while busy, the word is abandoned. No write occurs, and the lines read 11 for the rest of its time in execute.
- R7: Each issued word writes exactly once. The write goes to register bits [15:12], and its value is register bits [19:16] rotated left by one, XOR the zero-extended bits [7:0].
- R8: A word on `bus_word` in a non-stalled cycle reaches execute after three non-stalled clock edges. Each edge moves the model by one stage.
- R9: While `host_stall` is high, the pipeline model does not advance. With the strobe high, the response lines hold their value.
- R10: Reset drives both response lines high, clears the pipeline model and clears every bank register to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 32 | Instruction word fetched by the host this cycle |
| host_stall | input | 1 | Host pipeline stalled this cycle; the model holds |
| host_cop_n | input | 1 | Active-low issue strobe for the word in execute |
| resp_absent | output | 1 | Response line: high means no unit accepts the word |
| resp_busy | output | 1 | Response line: high means not ready (or absent) |
| wr_en | output | 1 | Execution write pulse into the register bank |
| wr_idx | output | 4 | Destination register of the write |
| wr_data | output | DATA_W | Value written |

## Verification
The checker watches these rules on every cycle:
- the code 10 never appears;
- a write happens only with the strobe low and the lines at 00;
- absent stays low through a stalled busy-wait;
- an abandon produces no write and releases the lines to 11;
- a stall with the strobe high freezes the response;
- reset leaves the lines idle.

Other behaviour shows only through the bench's scenarios, which run against a bench-side model of the host and the bank:
- the exact busy length and its clamping;
- the three-edge pipeline delay;
- the decode of both instruction classes;
- the written register and its value;
- retrying a word after it was abandoned.

// File: rtl/cophs_pkg.sv
package cophs_pkg;

  localparam int FIELD_W = 4;
  localparam int IMM_W   = 8;
  localparam int TRACK_W = 28;

  typedef struct packed {
    logic               valid;
    logic               mine;
    logic [FIELD_W-1:0] crd;
    logic [FIELD_W-1:0] crn;
    logic [IMM_W-1:0]   imm;
  } dec_t;

  function automatic logic is_cop_class(input logic [TRACK_W-1:0] w);
    return (w[27:24] == 4'b1110) || (w[27:25] == 3'b110);
  endfunction

  function automatic logic [FIELD_W-1:0] clamp_wait(input logic [FIELD_W-1:0] f,
                                                    input logic [FIELD_W-1:0] lim);
    return (f > lim) ? lim : f;
  endfunction

  function automatic dec_t decode_word(input logic [TRACK_W-1:0] w,
                                       input logic vld,
                                       input logic [FIELD_W-1:0] id);
    dec_t d;
    d.valid = vld;
    d.mine  = vld && is_cop_class(w) && (w[11:8] == id);
    d.crd   = w[15:12];
    d.crn   = w[19:16];
    d.imm   = w[7:0];
    return d;
  endfunction

endpackage

// File: rtl/cophs_pipe.sv
module cophs_pipe
  import cophs_pkg::*;
#(
  parameter int CP_ID    = 5,
  parameter int MAX_WAIT = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic [TRACK_W-1:0] fetch_word,
  output dec_t               e_q,
  output logic [FIELD_W-1:0] d_wait
);

  localparam logic [FIELD_W-1:0] ID_V  = FIELD_W'(CP_ID);
  localparam logic [FIELD_W-1:0] LIM_V = FIELD_W'(MAX_WAIT);

  logic [TRACK_W-1:0] f_word, d_word;
  logic               f_vld, d_vld;
  dec_t               d_dec;

  assign d_dec  = decode_word(d_word, d_vld, ID_V);
  assign d_wait = clamp_wait(d_word[23:20], LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_word <= '0;
      d_word <= '0;
      f_vld  <= 1'b0;
      d_vld  <= 1'b0;
      e_q    <= '0;
    end else if (advance) begin
      f_word <= fetch_word;
      f_vld  <= 1'b1;
      d_word <= f_word;
      d_vld  <= f_vld;
      e_q    <= d_dec;
    end
  end

endmodule

// File: rtl/cophs_engine.sv
module cophs_engine
  import cophs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               cop_n,
  input  logic               e_mine,
  input  logic [FIELD_W-1:0] next_wait,
  output logic               resp_absent,
  output logic               resp_busy,
  output logic               commit,
  output logic               abandon
);

  logic [FIELD_W-1:0] cnt;
  logic               done_q, seen_q, killed_q;
  logic               live, waiting, strobe;

  assign live    = e_mine && !killed_q;
  assign waiting = (cnt != '0);
  assign strobe  = !cop_n;

  assign commit      = live && !done_q && strobe && !waiting;
  assign abandon     = live && !done_q && seen_q && cop_n;
  assign resp_absent = !live;
  assign resp_busy   = !live || (!done_q && waiting);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      done_q   <= 1'b0;
      seen_q   <= 1'b0;
      killed_q <= 1'b0;
    end else if (advance) begin
      cnt      <= next_wait;
      done_q   <= 1'b0;
      seen_q   <= 1'b0;
      killed_q <= 1'b0;
    end else begin
      if (commit) done_q <= 1'b1;
      if (live && !done_q && strobe && waiting) cnt <= cnt - 1'b1;
      if (live && strobe) seen_q <= 1'b1;
      if (abandon) killed_q <= 1'b1;
    end
  end

endmodule

// File: rtl/cophs_regbank.sv
module cophs_regbank #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);

  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][DATA_W-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (we && (widx == IDX_W'(g)))     q <= wdata;
    end
    assign flat[g] = q;
  end

  assign rdata = flat[ridx];

endmodule

// File: rtl/cophs_unit.sv
module cophs_unit
  import cophs_pkg::*;
#(
  parameter int CP_ID    = 5,
  parameter int MAX_WAIT = 6,
  parameter int DATA_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       bus_word,
  input  logic              host_stall,
  input  logic              host_cop_n,
  output logic              resp_absent,
  output logic              resp_busy,
  output logic              wr_en,
  output logic [3:0]        wr_idx,
  output logic [DATA_W-1:0] wr_data
);

  function automatic logic [DATA_W-1:0] exec_value(input logic [DATA_W-1:0] src,
                                                    input logic [IMM_W-1:0] imm);
    return {src[DATA_W-2:0], src[DATA_W-1]} ^ DATA_W'(imm);
  endfunction

  dec_t               e_q;
  logic [FIELD_W-1:0] d_wait;
  logic [DATA_W-1:0]  src_val;
  logic               advance;
  logic               commit_ev;
  logic               abandon_ev;
  logic               unused_cond;

  assign advance     = !host_stall;
  assign unused_cond = ^bus_word[31:28];

  cophs_pipe #(.CP_ID(CP_ID), .MAX_WAIT(MAX_WAIT)) u_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .advance    (advance),
    .fetch_word (bus_word[TRACK_W-1:0]),
    .e_q        (e_q),
    .d_wait     (d_wait)
  );

  cophs_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .cop_n       (host_cop_n),
    .e_mine      (e_q.mine),
    .next_wait   (d_wait),
    .resp_absent (resp_absent),
    .resp_busy   (resp_busy),
    .commit      (commit_ev),
    .abandon     (abandon_ev)
  );

  cophs_regbank #(.DATA_W(DATA_W), .IDX_W(FIELD_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (commit_ev),
    .widx  (e_q.crd),
    .wdata (wr_data),
    .ridx  (e_q.crn),
    .rdata (src_val)
  );

  assign wr_en   = commit_ev;
  assign wr_idx  = e_q.crd;
  assign wr_data = exec_value(src_val, e_q.imm);

endmodule

// File: rtl/cophs_checker.sv
module cophs_checker (
  input logic clk,
  input logic rst_n,
  input logic host_stall,
  input logic host_cop_n,
  input logic resp_absent,
  input logic resp_busy,
  input logic wr_en,
  input logic abandon_ev
);

  AST_NO_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_absent && !resp_busy)); // R2

  AST_WRITE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !host_cop_n); // R4

  AST_WRITE_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!resp_absent && !resp_busy)); // R5

  AST_BUSY_KEEPS_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!resp_absent && resp_busy && !host_cop_n && host_stall) |=> !resp_absent); // R5

  AST_ABANDON_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    abandon_ev |-> !wr_en); // R6

  AST_ABANDON_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (abandon_ev && host_stall) |=> (resp_absent && resp_busy)); // R6

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && host_stall) |=> !wr_en); // R7

  AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_stall && host_cop_n && !abandon_ev) |=> $stable({resp_absent, resp_busy})); // R9

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (resp_absent && resp_busy && !wr_en)); // R10

endmodule

bind cophs_unit cophs_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_stall  (host_stall),
  .host_cop_n  (host_cop_n),
  .resp_absent (resp_absent),
  .resp_busy   (resp_busy),
  .wr_en       (wr_en),
  .abandon_ev  (abandon_ev)
);

// File: tb/tb_cophs_unit.sv
module tb_cophs_unit;

  localparam int CP_ID    = 5;
  localparam int MAX_WAIT = 6;
  localparam int DATA_W   = 32;
  localparam int N_CYC    = 30000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       bus_word = '0;
  logic              host_stall = 1'b0;
  logic              host_cop_n = 1'b1;
  logic              resp_absent, resp_busy, wr_en;
  logic [3:0]        wr_idx;
  logic [DATA_W-1:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cophs_unit #(.CP_ID(CP_ID), .MAX_WAIT(MAX_WAIT), .DATA_W(DATA_W)) dut (.*);

  // bench-side model of the pipeline and bank
  logic [31:0]       mF, mD, mE;
  bit                vF, vD, vE;
  int                cnt, age;
  bit                done, seen, killed, cond, prev_stall;
  logic [DATA_W-1:0] regs [16];
  logic [31:0]       dir_w [8];

  function automatic bit m_class(input logic [31:0] w);
    return (w[27:24] == 4'hE) || (w[27:25] == 3'b110);
  endfunction
  function automatic bit m_mine(input logic [31:0] w);
    return m_class(w) && (int'(w[11:8]) == CP_ID);
  endfunction
  function automatic int m_wait(input logic [31:0] w);
    return (int'(w[23:20]) > MAX_WAIT) ? MAX_WAIT : int'(w[23:20]);
  endfunction
  function automatic logic [DATA_W-1:0] m_res(input logic [DATA_W-1:0] r, input logic [7:0] imm);
    logic [DATA_W-1:0] t;
    t = (r << 1) | (r >> (DATA_W - 1));
    return t ^ {{(DATA_W-8){1'b0}}, imm};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] rand_word();
    logic [31:0] w;
    int k;
    w = $urandom;
    k = $urandom_range(0, 9);
    if (k < 6) begin
      if (k < 3) w[27:24] = 4'hE; else w[27:25] = 3'b110;
      w[11:8] = (k == 5) ? 4'(($urandom_range(0, 14) + CP_ID + 1) % 16) : 4'(CP_ID);
    end
    return w;
  endfunction

  initial begin
    void'($urandom(32'd51731));
    dir_w[0] = 32'hEE00153C; // wait 0, immediate
    dir_w[1] = 32'hE0002501; // not coprocessor class
    dir_w[2] = 32'hEE102301; // other coprocessor number
    dir_w[3] = 32'hEC312512; // 110 class, wait 3
    dir_w[4] = 32'hEEF23577; // wait 15 clamps to MAX_WAIT
    dir_w[5] = 32'hEE2145AA; // abandoned while busy
    dir_w[6] = 32'hEE2145AB; // retried
    dir_w[7] = 32'hED121501; // 110 class via 1101, wait 1
    mF = '0; mD = '0; mE = '0;
    vF = 0; vD = 0; vE = 0;
    cnt = 0; age = 0; done = 0; seen = 0; killed = 0; cond = 0; prev_stall = 0;
    for (int i = 0; i < 16; i++) regs[i] = '0;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 absent in reset", 64'(resp_absent), 64'd1);
    chk("R10 busy in reset", 64'(resp_busy), 64'd1);
    chk("R10 no write in reset", 64'(wr_en), 64'd0);
    rst_n = 1'b1;

    for (int cyc = 0; cyc < N_CYC; cyc++) begin
      bit live, ew, ea, eb, stl, cpn, abn;
      logic [31:0] w;
      logic [DATA_W-1:0] res;
      string ta, tb, tw;
      live = vE && m_mine(mE) && !killed;
      // host decision
      cpn = 1'b1;
      stl = ($urandom_range(0, 7) == 0);
      if (vE && m_class(mE) && cond && !done && !killed) begin
        if (m_mine(mE)) begin
          if (cnt != 0) begin
            if (seen && (mE[7:0] == 8'hAA || $urandom_range(0, 5) == 0)) begin
              cpn = 1'b1;
              stl = (mE[7:0] == 8'hAA) ? 1'b1 : 1'($urandom_range(0, 1));
            end else begin
              cpn = 1'b0; stl = 1'b1;
            end
          end else begin
            cpn = 1'b0; stl = 1'b0;
          end
        end else begin
          cpn = 1'b0; stl = 1'b0;
        end
      end
      w = (cyc < 8) ? dir_w[cyc] : rand_word();
      if (cyc < 8) stl = 1'b0;
      bus_word = w; host_stall = stl; host_cop_n = cpn;
      #1;
      ea = !live;
      eb = !live || (!done && cnt != 0);
      ew = live && !done && !cpn && (cnt == 0);
      ta = killed ? "R6 absent after abandon" : (prev_stall && age > 0) ? "R9 absent held by stall" :
           (age == 0) ? "R8 absent on entry to execute" : "R1 absent decode";
      tb = (age == 0 && cpn) ? "R3 busy before strobe" : "R5 busy length";
      tw = killed ? "R6 no write after abandon" : cpn ? "R4 no write without strobe" : "R7 write pulse";
      chk(ta, 64'(resp_absent), 64'(ea));
      chk(tb, 64'(resp_busy), 64'(eb));
      chk("R2 no invalid code", 64'(resp_absent && !resp_busy), 64'd0);
      chk(tw, 64'(wr_en), 64'(ew));
      res = m_res(regs[mE[19:16]], mE[7:0]);
      if (ew && wr_en) begin
        chk("R7 write index", 64'(wr_idx), 64'(mE[15:12]));
        chk("R7 write value", 64'(wr_data), 64'(res));
      end
      // model update for the coming edge
      abn = live && !done && seen && cpn;
      if (ew) regs[mE[15:12]] = res;
      if (stl) begin
        if (ew) done = 1;
        if (live && !done && !cpn && cnt != 0) cnt--;
        if (live && !cpn) seen = 1;
        if (abn) killed = 1;
        age++;
      end else begin
        mE = mD; vE = vD;
        cnt = m_wait(mD);
        done = 0; seen = 0; killed = 0; age = 0;
        cond = (cyc < 12) ? 1'b1 : ($urandom_range(0, 7) != 0);
        mD = mF; vD = vF;
        mF = w; vF = 1;
      end
      prev_stall = stl;
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule